// File: doc/BRIEF.md
# Dual-Port Doorbell Interrupt Flags

This block produces a doorbell interrupt for each side of a shared two-port memory. It watches the bus signals of both ports: select, write strobe, read strobe, address and the arbitration stall. It does not hold any data. The two highest word addresses of the memory act as mailboxes. The highest word belongs to the right port and the word below it belongs to the left port.

To ring a peer, a port writes the peer's mailbox word. The message itself is stored in the memory array as usual, and this block only raises the peer's flag. The receiving port acknowledges by reading its own mailbox word, and that read lowers its flag. A global enable turns the whole mechanism off. When it is off, the two words act as plain storage and the flags keep their present value.

All inputs are sampled on the rising clock edge. A qualifying access changes the registered flag at that same edge.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset, both `intLeft` and `intRight` are 0.
- R2: The right port writes the left mailbox (address 2^ADDR_W-2, 0x1FFE by default). This requires `rSel=1`, `rWr=1`, `rBusy=0` and `mbxEnable=1`. `intLeft` is then 1 from the next clock edge.
- R3: The left port writes the right mailbox (address 2^ADDR_W-1, 0x1FFF by default). This requires `lSel=1`, `lWr=1`, `lBusy=0` and `mbxEnable=1`. `intRight` is then 1 from the next clock edge.
- R4: A left-port read of 0x1FFE (`lSel=1`, `lRd=1`, `lBusy=0`, `mbxEnable=1`) clears `intLeft` at the next edge. The level of `lWr` makes no difference.
- R5: A right-port read of 0x1FFF (`rSel=1`, `rRd=1`, `rBusy=0`, `mbxEnable=1`) clears `intRight` at the next edge.
- R6: While a port's busy input is 1, that port's mailbox writes and mailbox reads change neither flag.
- R7: A set and a clear of the same flag can land in one cycle. The flag is then 1 after the edge.
- R8: While `mbxEnable` is 0, no access changes either flag.
- R9: The following change no flag: accesses to other addresses, a port writing its own mailbox, a port reading the peer's mailbox, and accesses with select low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mbxEnable | input | 1 | Enables the mailbox interrupt function |
| lSel | input | 1 | Left port select, active high |
| lWr | input | 1 | Left port write strobe |
| lRd | input | 1 | Left port read (output) enable |
| lBusy | input | 1 | Left port stalled by arbitration |
| lAddr | input | ADDR_W | Left port word address |
| rSel | input | 1 | Right port select, active high |
| rWr | input | 1 | Right port write strobe |
| rRd | input | 1 | Right port read (output) enable |
| rBusy | input | 1 | Right port stalled by arbitration |
| rAddr | input | ADDR_W | Right port word address |
| intLeft | output | 1 | Doorbell flag for the left port |
| intRight | output | 1 | Doorbell flag for the right port |

## Verification
The stimulus sequence covers five situations:
- Correct-port writes and reads. These show that both the direction of each doorbell and its acknowledge work.
- Accesses by the wrong port, to the wrong word or to an ordinary address. These separate the address and port decoding from plain write detection.
- The same accesses with busy raised and with the global enable low. These show that every qualifying term gates both the set and the clear.
- A read of the mailbox with the write strobe also high. This confirms that the clear ignores the strobe.
- A set and a clear arriving in one cycle, and both doorbells rung together. These expose any wrong priority or any coupling between the two flags.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;
  localparam int NUM_PORTS  = 2;

  typedef struct packed {
    logic setLeft;
    logic clrLeft;
    logic setRight;
    logic clrRight;
  } mbx_strobe_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_ADDR  = '0,
  parameter logic [ADDR_W-1:0] PEER_ADDR = '0
) (
  input  logic              enable,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              setPeer,
  output logic              clrOwn
);
  logic granted;

  always_comb begin
    granted = enable & sel & ~busy;
    setPeer = granted & wr & (addr == PEER_ADDR);
    clrOwn  = granted & rd & (addr == OWN_ADDR);
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              mbxEnable,
  input  logic [NUM_PORTS-1:0]              sel,
  input  logic [NUM_PORTS-1:0]              wr,
  input  logic [NUM_PORTS-1:0]              rd,
  input  logic [NUM_PORTS-1:0]              busy,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr,
  output mbx_strobe_t                       strb
);
  localparam logic [ADDR_W-1:0] MBX_RIGHT = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBX_LEFT  = MBX_RIGHT - 1'b1;

  logic [NUM_PORTS-1:0] setPeer;
  logic [NUM_PORTS-1:0] clrOwn;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == PORT_LEFT) ? MBX_LEFT : MBX_RIGHT;
    localparam logic [ADDR_W-1:0] PEER = (p == PORT_LEFT) ? MBX_RIGHT : MBX_LEFT;
    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .OWN_ADDR (OWN),
      .PEER_ADDR(PEER)
    ) i_decode (
      .enable (mbxEnable),
      .sel    (sel[p]),
      .wr     (wr[p]),
      .rd     (rd[p]),
      .busy   (busy[p]),
      .addr   (addr[p]),
      .setPeer(setPeer[p]),
      .clrOwn (clrOwn[p])
    );
  end

  always_comb begin
    strb.setLeft  = setPeer[PORT_RIGHT];
    strb.clrLeft  = clrOwn[PORT_LEFT];
    strb.setRight = setPeer[PORT_LEFT];
    strb.clrRight = clrOwn[PORT_RIGHT];
  end

  // R6: a stalled port produces no strobe of its own
  assert_left_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy[PORT_LEFT] |-> !(strb.clrLeft || strb.setRight));
  assert_right_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy[PORT_RIGHT] |-> !(strb.clrRight || strb.setLeft));
  // R8: disabled mailboxes raise no strobe
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !mbxEnable |-> (strb == '0));
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mbx_strobe_t strb,
  output logic        intLeft,
  output logic        intRight
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intLeft  <= 1'b0;
      intRight <= 1'b0;
    end else begin
      if (strb.setLeft)       intLeft <= 1'b1;
      else if (strb.clrLeft)  intLeft <= 1'b0;
      if (strb.setRight)      intRight <= 1'b1;
      else if (strb.clrRight) intRight <= 1'b0;
    end
  end

  // R2 and R7: a set always wins
  assert_set_left_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLeft |=> intLeft);
  assert_set_right_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRight |=> intRight);
  assert_clear_left_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLeft && !strb.setLeft) |=> !intLeft);
  assert_clear_right_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrRight && !strb.setRight) |=> !intRight);
  // R8 and R9: without a strobe the flags hold
  assert_hold_left_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setLeft && !strb.clrLeft) |=> $stable(intLeft));
  assert_hold_right_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setRight && !strb.clrRight) |=> $stable(intRight));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mbxEnable,
  input  logic              lSel,
  input  logic              lWr,
  input  logic              lRd,
  input  logic              lBusy,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rSel,
  input  logic              rWr,
  input  logic              rRd,
  input  logic              rBusy,
  input  logic [ADDR_W-1:0] rAddr,
  output logic              intLeft,
  output logic              intRight
);
  mbx_strobe_t strb;

  mbx_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mbxEnable(mbxEnable),
    .sel      ({rSel, lSel}),
    .wr       ({rWr, lWr}),
    .rd       ({rRd, lRd}),
    .busy     ({rBusy, lBusy}),
    .addr     ({rAddr, lAddr}),
    .strb     (strb)
  );

  mbx_flags i_flags (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .intLeft (intLeft),
    .intRight(intRight)
  );
endmodule

// File: tb/test_mbx_doorbell.sv
module test_mbx_doorbell;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] BOX_L = 13'h1FFE;
  localparam logic [ADDR_W-1:0] BOX_R = 13'h1FFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mbxEnable = 1'b1;
  logic lSel = 0, lWr = 0, lRd = 0, lBusy = 0;
  logic rSel = 0, rWr = 0, rRd = 0, rBusy = 0;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic intLeft, intRight;

  int checks = 0;
  int errors = 0;
  logic [1:0] expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_doorbell #(.ADDR_W(ADDR_W)) i_mbx_doorbell (
    .clk(clk), .rstN(rstN), .mbxEnable(mbxEnable),
    .lSel(lSel), .lWr(lWr), .lRd(lRd), .lBusy(lBusy), .lAddr(lAddr),
    .rSel(rSel), .rWr(rWr), .rRd(rRd), .rBusy(rBusy), .rAddr(rAddr),
    .intLeft(intLeft), .intRight(intRight)
  );

  task automatic compare(input logic [1:0] exp, input string tag);
    checks++;
    if ({intLeft, intRight} !== exp) begin
      errors++;
      $display("FAIL %s: {intLeft,intRight} actual %b expected %b", tag, {intLeft, intRight}, exp);
    end
  endtask

  // monitor: results become visible at the negedge after the driving cycle
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      compare(expQ.pop_front(), tagQ.pop_front());
    end
  end

  // driver: one bus cycle, then the expected flags go to the scoreboard
  task automatic step(
    input logic ls, lw, lr, lb, input logic [ADDR_W-1:0] la,
    input logic rs, rw, rr, rb, input logic [ADDR_W-1:0] ra,
    input logic en, input logic expL, expR, input string tag);
    @(negedge clk);
    lSel = ls; lWr = lw; lRd = lr; lBusy = lb; lAddr = la;
    rSel = rs; rWr = rw; rRd = rr; rBusy = rb; rAddr = ra;
    mbxEnable = en;
    @(posedge clk);
    expQ.push_back({expL, expR});
    tagQ.push_back(tag);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compare(2'b00, "R1 reset state");
    // R9 wrong word, wrong port, ordinary address
    step(0,0,0,0,'0,      1,1,0,0,BOX_R,  1, 0,0, "R9 right writes own box");
    step(1,1,0,0,BOX_L,   0,0,0,0,'0,     1, 0,0, "R9 left writes own box");
    step(0,0,0,0,'0,      1,1,0,0,13'h0123, 1, 0,0, "R9 ordinary address");
    step(0,0,0,0,'0,      1,1,0,1,BOX_L,  1, 0,0, "R6 right busy blocks set");
    step(0,0,0,0,'0,      1,1,0,0,BOX_L,  1, 1,0, "R2 right rings left");
    step(0,0,0,0,'0,      1,0,1,0,BOX_L,  1, 1,0, "R9 right reads peer box");
    step(1,0,1,1,BOX_L,   0,0,0,0,'0,     1, 1,0, "R6 left busy blocks clear");
    step(1,1,1,0,BOX_L,   0,0,0,0,'0,     1, 0,0, "R4 left read clears, strobe high");
    step(1,1,0,0,BOX_R,   0,0,0,0,'0,     1, 0,1, "R3 left rings right");
    step(0,1,1,0,BOX_L,   0,0,0,0,'0,     1, 0,1, "R9 select low ignored");
    step(0,0,0,0,'0,      1,0,1,0,BOX_R,  0, 0,1, "R8 disabled clear ignored");
    step(0,0,0,0,'0,      1,1,0,0,BOX_L,  0, 0,1, "R8 disabled set ignored");
    step(0,0,0,0,'0,      1,0,1,0,BOX_R,  1, 0,0, "R5 right read clears");
    step(0,0,0,0,'0,      1,1,0,0,BOX_L,  1, 1,0, "R2 set again");
    step(1,0,1,0,BOX_L,   1,1,0,0,BOX_L,  1, 1,0, "R7 set wins over clear");
    step(1,0,1,0,BOX_L,   0,0,0,0,'0,     1, 0,0, "R4 clear after priority");
    step(1,1,0,0,BOX_R,   1,1,0,0,BOX_L,  1, 1,1, "R2 R3 both rung together");
    step(1,0,1,0,BOX_L,   1,0,1,0,BOX_R,  1, 0,0, "R4 R5 both cleared together");
    step(0,0,0,0,'0,      0,0,0,0,'0,     1, 0,0, "R9 idle holds");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule